// File: doc/BRIEF.md
# AXI Bus Latency and Throughput Monitor

This block sits beside one AXI interface and watches its handshakes without driving any of them. It keeps six running totals: bytes moved, summed latency and completed transactions, each for the write side and for the read side. Software takes readings at a fixed interval, about 50 ms by default. It derives throughput from the change in a byte total over that interval. It derives average latency by dividing the change in a latency total by the change in the matching transaction total.

A transaction opens when its address handshake completes (AW or AR valid and ready high together). A write closes on the response handshake (B valid and ready). A read closes on the handshake of the beat that carries the last flag. Each cycle, every latency total grows by the number of transactions open in its direction. This equals the sum of each transaction's own open-to-close cycle count, for up to 32 open transactions per direction. Transactions must complete in order: interleaved read data is not supported. A small register port gives a synchronous clear and a snapshot strobe, and a select input picks which captured total appears on the read data output. Back-pressure is never applied: the monitor only samples the valid/ready pairs, so a beat counts only in a cycle where both are high.

Top module: `axi_perf_mon`

## Requirements
- R1: After reset every total and every captured snapshot value reads as zero.
- R2: A byte total grows by DATA_W/8 for each data beat whose valid and ready are both high (W for writes, R for reads). A beat offered with ready low adds nothing.
- R3: The write transaction total grows by one on each B handshake. The read transaction total grows by one on each R handshake with the last flag set. A read beat without the last flag leaves it unchanged.
- R4: When a transaction opens at clock edge s and closes at edge e, it contributes exactly e - s to its latency total. This holds with overlapping transactions, up to MAX_OUT open per direction.
- R5: Outside a clear, a total never decreases.
- R6: A clear strobe sets all six totals to zero at that edge and overrides any increment in the same cycle. The tracking of open transactions is kept.
- R7: A snapshot strobe copies all six totals, as they stood before that edge, into the snapshot bank. The bank then holds those values until the next strobe. A clear in the same cycle does not alter what is captured.
- R8: rd_data shows the snapshot selected by rd_sel: 0 write bytes, 1 write latency, 2 write transactions, 3 read bytes, 4 read latency, 5 read transactions. Codes 6 and 7 read zero.
- R9: The count of open transactions per direction never exceeds MAX_OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid (observed) |
| aw_ready | input | 1 | Write address ready (observed) |
| w_valid | input | 1 | Write data valid (observed) |
| w_ready | input | 1 | Write data ready (observed) |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_last | input | 1 | Read data last beat (observed) |
| clr | input | 1 | Synchronous clear of all six totals |
| snap | input | 1 | Capture all six totals into the snapshot bank |
| rd_sel | input | 3 | Snapshot select |
| rd_data | output | 64 | Selected snapshot value |

## Verification
A wrong count of open transactions does not show up as a single bad value. It makes the latency total drift by one on every later cycle until that direction drains, so the error becomes visible at the next snapshot taken after the direction drains. A byte or transaction slip shows up as an exact mismatch at the next snapshot. A snapshot bank that fails to hold its values shows up on a later read that has no strobe in between. Checks are therefore made only with both directions drained, so each expected total is a closed sum of per-transaction figures.

// File: rtl/axi_perf_pkg.sv
package axi_perf_pkg;
  localparam int NUM_CNT = 6;
  typedef enum logic [2:0] {
    IDX_WR_BYTES = 3'd0,
    IDX_WR_LAT   = 3'd1,
    IDX_WR_TXN   = 3'd2,
    IDX_RD_BYTES = 3'd3,
    IDX_RD_LAT   = 3'd4,
    IDX_RD_TXN   = 3'd5
  } cnt_idx_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/axi_perf_occ.sv
module axi_perf_occ #(
  parameter int MAX_OUT = 32,
  parameter int OCC_W   = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  output logic [OCC_W-1:0] occ_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_o <= '0;
    else        occ_o <= occ_o + OCC_W'(open_i) - OCC_W'(close_i);
  end
endmodule

// File: rtl/axi_perf_accum.sv
module axi_perf_accum #(
  parameter int CNT_W = 64,
  parameter int ADD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [ADD_W-1:0] add_i,
  output logic [CNT_W-1:0] total_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     total_o <= '0;
    else if (clr_i) total_o <= '0;
    else            total_o <= total_o + CNT_W'(add_i);
  end
endmodule

// File: rtl/axi_perf_mon.sv
module axi_perf_mon #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 64,
  parameter int MAX_OUT = 32,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             b_valid,
  input  logic             b_ready,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  input  logic             clr,
  input  logic             snap,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  import axi_perf_pkg::*;

  localparam int BYTES   = DATA_W / 8;
  localparam int BYTES_W = $clog2(BYTES + 1);
  localparam int OCC_W   = $clog2(MAX_OUT + 1);
  localparam int ADD_W   = max2(BYTES_W, OCC_W);

  logic aw_hs, w_hs, b_hs, ar_hs, r_hs, rl_hs;
  assign aw_hs = aw_valid & aw_ready;
  assign w_hs  = w_valid & w_ready;
  assign b_hs  = b_valid & b_ready;
  assign ar_hs = ar_valid & ar_ready;
  assign r_hs  = r_valid & r_ready;
  assign rl_hs = r_hs & r_last;

  logic [OCC_W-1:0] wr_occ, rd_occ;

  axi_perf_occ #(.MAX_OUT(MAX_OUT), .OCC_W(OCC_W)) i_wr_occ (
    .clk(clk), .rst_n(rst_n), .open_i(aw_hs), .close_i(b_hs), .occ_o(wr_occ));
  axi_perf_occ #(.MAX_OUT(MAX_OUT), .OCC_W(OCC_W)) i_rd_occ (
    .clk(clk), .rst_n(rst_n), .open_i(ar_hs), .close_i(rl_hs), .occ_o(rd_occ));

  logic [NUM_CNT-1:0][ADD_W-1:0] add_amt;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0][CNT_W-1:0] snap_q;

  always_comb begin
    add_amt               = '0;
    add_amt[IDX_WR_BYTES] = w_hs ? ADD_W'(BYTES) : '0;
    add_amt[IDX_WR_LAT]   = ADD_W'(wr_occ);
    add_amt[IDX_WR_TXN]   = ADD_W'(b_hs);
    add_amt[IDX_RD_BYTES] = r_hs ? ADD_W'(BYTES) : '0;
    add_amt[IDX_RD_LAT]   = ADD_W'(rd_occ);
    add_amt[IDX_RD_TXN]   = ADD_W'(rl_hs);
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    axi_perf_accum #(.CNT_W(CNT_W), .ADD_W(ADD_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .clr_i(clr),
      .add_i(add_amt[g]), .total_o(cnt[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap_q[g] <= '0;
      else if (snap) snap_q[g] <= cnt[g];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_sel == SEL_W'(i)) rd_data = snap_q[i];
    end
  end
endmodule

// File: rtl/axi_perf_mon_chk.sv
module axi_perf_mon_chk #(
  parameter int CNT_W   = 64,
  parameter int BYTES   = 8,
  parameter int MAX_OUT = 32,
  parameter int OCC_W   = 6,
  parameter int NUM     = 6
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      w_hs,
  input logic                      b_hs,
  input logic                      r_hs,
  input logic                      rl_hs,
  input logic                      clr,
  input logic                      snap,
  input logic [OCC_W-1:0]          wr_occ,
  input logic [OCC_W-1:0]          rd_occ,
  input logic [NUM-1:0][CNT_W-1:0] cnt,
  input logic [NUM-1:0][CNT_W-1:0] snap_q
);
  assert_wbyte_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hs && !clr) |=> cnt[0] == $past(cnt[0]) + CNT_W'(BYTES));
  assert_rbyte_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_hs && !clr) |=> $stable(cnt[3]));
  assert_wtxn_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hs && !clr) |=> cnt[2] == $past(cnt[2]) + 1);
  assert_rtxn_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rl_hs && !clr) |=> $stable(cnt[5]));
  assert_lat_mono_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt[1] >= $past(cnt[1])) && (cnt[4] >= $past(cnt[4])));
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt[0] == '0) && (cnt[2] == '0) && (cnt[4] == '0));
  assert_snap_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (snap_q[1] == $past(cnt[1])) && (snap_q[5] == $past(cnt[5])));
  assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(snap_q));
  assert_occ_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_occ <= OCC_W'(MAX_OUT)) && (rd_occ <= OCC_W'(MAX_OUT)));
endmodule

bind axi_perf_mon axi_perf_mon_chk #(
  .CNT_W(CNT_W), .BYTES(BYTES), .MAX_OUT(MAX_OUT), .OCC_W(OCC_W),
  .NUM(axi_perf_pkg::NUM_CNT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .w_hs(w_hs), .b_hs(b_hs), .r_hs(r_hs),
  .rl_hs(rl_hs), .clr(clr), .snap(snap), .wr_occ(wr_occ), .rd_occ(rd_occ),
  .cnt(cnt), .snap_q(snap_q)
);

// File: tb/test_axi_perf_mon.sv
module test_axi_perf_mon;
  localparam int BYTES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aw_valid = 0, aw_ready = 0, w_valid = 0, w_ready = 0;
  logic b_valid = 0, b_ready = 0, ar_valid = 0, ar_ready = 0;
  logic r_valid = 0, r_ready = 0, r_last = 0, clr = 0, snap = 0;
  logic [2:0] rd_sel = '0;
  logic [63:0] rd_data;

  always #10 clk = ~clk;

  axi_perf_mon i_axi_perf_mon (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .w_valid(w_valid), .w_ready(w_ready),
    .b_valid(b_valid), .b_ready(b_ready), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
    .clr(clr), .snap(snap), .rd_sel(rd_sel), .rd_data(rd_data));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  longint unsigned exp_cnt [6];
  longint unsigned exp_snap[6];
  int wq[$];
  int rq[$];

  task automatic check(input int sel, input longint unsigned expv, input string tag);
    rd_sel = 3'(sel);
    #1;
    total++;
    if (rd_data !== expv) begin
      bad++;
      $display("FAIL %s sel=%0d actual=%0d expected=%0d", tag, sel, rd_data, expv);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 6; i++) check(i, exp_snap[i], tag);
  endtask

  // Drives one cycle from just after a falling edge, updates the model.
  task automatic step(input logic awv, awr, wv, wr, bv, br, arv, arr,
                      rv, rr, rl, cl, sn);
    if (wq.size() == 0) bv = 0;
    if (rq.size() == 0) rv = 0;
    if (wq.size() >= 32) awv = 0;
    if (rq.size() >= 32) arv = 0;
    aw_valid = awv; aw_ready = awr; w_valid = wv; w_ready = wr;
    b_valid = bv; b_ready = br; ar_valid = arv; ar_ready = arr;
    r_valid = rv; r_ready = rr; r_last = rl; clr = cl; snap = sn;
    if (sn) for (int i = 0; i < 6; i++) exp_snap[i] = exp_cnt[i];
    if (bv && br) begin
      int s = wq.pop_front();
      if (!cl) begin exp_cnt[1] += longint'(cyc - s); exp_cnt[2]++; end
    end
    if (rv && rr && rl) begin
      int s = rq.pop_front();
      if (!cl) begin exp_cnt[4] += longint'(cyc - s); exp_cnt[5]++; end
    end
    if (awv && awr) wq.push_back(cyc);
    if (arv && arr) rq.push_back(cyc);
    if (!cl) begin
      if (wv && wr) exp_cnt[0] += BYTES;
      if (rv && rr) exp_cnt[3] += BYTES;
    end else begin
      for (int i = 0; i < 6; i++) exp_cnt[i] = 0;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0,0,0,0,0,0,0,0,0,0,0,0,0);
  endtask

  task automatic drain();
    while (wq.size() > 0 || rq.size() > 0)
      step(0,0,0,0,1,($urandom%3)!=0,0,0,1,1,($urandom%2)==1,0,0);
  endtask

  task automatic rand_run(input int n, input int p_open, input int p_close);
    for (int i = 0; i < n; i++)
      step(($urandom%100) < p_open, $urandom%2, $urandom%2, $urandom%2,
           ($urandom%100) < p_close, $urandom%2,
           ($urandom%100) < p_open, $urandom%2,
           $urandom%2, $urandom%2, ($urandom%100) < p_close, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) begin exp_cnt[i] = 0; exp_snap[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    check(6, 0, "R8 unused code 6");
    check(7, 0, "R8 unused code 7");

    // R4 directed: read opens at edge k, closes at k+5
    step(0,0,0,0,0,0,1,1,0,0,0,0,0);
    idle(4);
    step(0,0,0,0,0,0,0,0,1,1,1,0,0);
    step(0,0,0,0,0,0,0,0,0,0,0,0,1);
    check(4, 64'd5, "R4 single read latency");
    check(5, 64'd1, "R3 single read txn");
    check(3, 64'd8, "R2 single read beat");

    // R2/R3: beats without ready, and non-last read beat
    step(1,1,0,0,0,0,1,1,0,0,0,0,0);
    step(0,0,1,0,1,0,0,0,1,0,1,0,0);
    step(0,0,0,0,0,0,0,0,1,1,0,0,0);
    step(0,0,0,0,1,1,0,0,1,1,1,0,0);
    step(0,0,0,0,0,0,0,0,0,0,0,0,1);
    check(0, 64'd0, "R2 write beat without ready ignored");
    check(3, 64'd24, "R2 read bytes with non-last beat");
    check(5, 64'd2, "R3 non-last beat not a txn");
    check(2, 64'd1, "R3 write txn on B handshake");
    check(1, 64'd3, "R4 write latency");
    check_all("R4 model after directed");

    // Random patterns, differing densities
    rand_run(300, 50, 50); drain(); step(0,0,0,0,0,0,0,0,0,0,0,0,1);
    check_all("R2 R3 R4 balanced random");
    rand_run(300, 90, 10); drain(); step(0,0,0,0,0,0,0,0,0,0,0,0,1);
    check_all("R4 deep outstanding random");
    rand_run(300, 15, 80); drain(); step(0,0,0,0,0,0,0,0,0,0,0,0,1);
    check_all("R3 sparse random");

    // R7: snapshot holds without a strobe
    rand_run(40, 60, 40);
    check_all("R7 snapshot hold");
    drain();

    // R6/R7: clear with snapshot and activity in the same cycle
    step(0,0,1,1,0,0,1,1,0,0,0,1,1);
    check_all("R7 capture before clear");
    idle(3);
    step(0,0,0,0,0,0,0,0,1,1,1,0,0);
    step(0,0,0,0,0,0,0,0,0,0,0,0,1);
    check(0, 64'd0, "R6 clear beats same-cycle beat");
    check(5, 64'd1, "R6 txn after clear");
    check(4, 64'd4, "R6 latency of read opened in clear cycle");
    check(2, 64'd0, "R6 write txn cleared");
    check_all("R6 model after clear");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule